// File: doc/BRIEF.md
# LCD Bias Supply Serial Control Slave

This block is the digital control side of an LCD bias supply. An SMBus master sets the supply with one data byte per write transaction. Each byte carries three things. It has a select bit that picks one of two configuration registers. It has a run bit and a panel-enable bit for that register. It also has a 5-bit DAC code, which is stored in a single shared register on every accepted byte. A master read addressed to the slave returns a status byte.

The two configuration registers are shadows: an operating register and a standby register. The external `awake_i` pin chooses which one drives the outputs. The DAC code does not depend on that choice, so it survives shutdown and pin changes. The power-good comparator input gates the panel enable whatever the registers hold. The synchronous active-low reset stands for power-up and undervoltage lockout. SCL and SDA arrive as sampled open-drain levels, and the block pulls SDA low through `sda_pull_o`. All inputs are brought into the clock domain through synchronizers.

Top module: `smb_bias_ctrl`

## Requirements
- R1: The slave responds only to the 7-bit address 0101100. Any other address gets no ACK, and a data byte that follows it changes no register.
- R2: Bit 7 of an accepted data byte selects the target register: 0 for standby, 1 for operating. Bit 6 is written as that register's run bit, where 0 means shutdown. Bit 5 is written as its panel-enable bit.
- R3: While `awake_i` is 1 the operating register drives `run_o` and `panel_en_o`. While it is 0 the standby register drives them.
- R4: Every accepted data byte loads its bits 4:0 into the DAC register, whatever bit 7 is.
- R5: `dac_o` keeps its value across `awake_i` changes, across shutdown, and across foreign-address traffic.
- R6: `run_o` is 0 when the active register's run bit is 0. `panel_en_o` is then 0 too. Writes are still accepted in shutdown, so the run bit can be set back to 1.
- R7: `panel_en_o` is 0 whenever `pgood_i` is 0.
- R8: Reset sets `dac_o` to 10000 binary. It sets both registers to run = 1 and panel = 0.
- R9: The slave pulls SDA low during the ninth clock after its address and after each written data byte. SDA changes only while SCL is low.
- R10: A read addressed to the slave (R/W bit 1) returns, MSB first, {awake, pgood, active run, active panel, 0000}. The byte is sent again after a master ACK, and SDA is released after a master NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset (power-up / undervoltage) |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_pull_o | output | 1 | 1 pulls the open-drain SDA line low |
| awake_i | input | 1 | 1 selects the operating register, 0 the standby register |
| pgood_i | input | 1 | Power-good comparator output |
| run_o | output | 1 | 1 = supply running, 0 = shutdown |
| panel_en_o | output | 1 | Panel connect switch enable |
| dac_o | output | 5 | DAC code |

## Verification
Two bus conditions are the hardest to reach from the ports, because neither occurs in a well-formed single-byte transfer. One is a read in which the master ACKs and keeps clocking. The other is a foreign address that the master follows with a full data byte anyway. The bench is a bit-level master that drives both cases on purpose. It reads two status bytes back to back and then ends with a NACK. It also walks every other address, each followed by a data byte that would visibly change the outputs if it were taken. All 256 data byte values are then written while the select pin and power-good follow patterns tied to the byte count, so that each value lands under several pin states.

// File: rtl/smb_bias_pkg.sv
// Package: shared types and defaults for the LCD bias serial control slave.
// Assumes: one configuration register holds exactly a run bit and a panel bit.
package smb_bias_pkg;

    localparam logic [6:0] DEF_SLAVE_ADDR = 7'b0101100;

    // One configuration register: run (0 = shutdown) and panel enable.
    typedef struct packed {
        logic run;
        logic panel;
    } bias_cfg_t;

    localparam bias_cfg_t CFG_RESET = '{run: 1'b1, panel: 1'b0};

    // Byte engine states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_DATA_ACK,
        ST_RDATA,
        ST_RD_ACK,
        ST_SKIP
    } smb_state_e;

    // Mid-scale code: MSB set, rest clear.
    function automatic logic [7:0] dac_mid(input int width);
        return 8'(1 << (width - 1));
    endfunction

endpackage

// File: rtl/bit_sync.sv
// Module: bit_sync
// Brings a vector of asynchronous levels into the clk domain through a chain
// of STAGES flops. Assumes every bit is a slow level or a bus line sampled
// far faster than it toggles.
module bit_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    // Shift the inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/smb_bus_engine.sv
// Module: smb_bus_engine
// Bit and byte engine of the SMBus slave. It detects START/STOP and the SCL
// edges, matches the address, collects written bytes and ACKs them. It
// shifts out the status byte on reads. Assumes SCL/SDA are synchronized
// already and that the master holds each SDA bit stable while SCL is high.
module smb_bus_engine
    import smb_bias_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = DEF_SLAVE_ADDR
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       sda_s,
    input  logic [7:0] status_i,
    output logic       sda_pull_o,
    output logic       wr_stb_o,
    output logic [7:0] wr_byte_o
);

    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    logic       scl_d, sda_d;
    logic       scl_rise, scl_fall, start_det, stop_det;
    smb_state_e state;
    logic [3:0] bit_cnt;
    logic [7:0] rx_sh, tx_sh;
    logic       rw_bit, mst_ack, pull_q;

    // Keep the previous line levels for edge and condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_d;
    assign scl_fall  = ~scl_s &  scl_d;
    assign start_det =  scl_s &  scl_d &  sda_d & ~sda_s;
    assign stop_det  =  scl_s &  scl_d & ~sda_d &  sda_s;

    // Transaction state machine: address, write bytes, read bytes, ACK slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rw_bit    <= 1'b0;
            mst_ack   <= 1'b0;
            pull_q    <= 1'b0;
            wr_stb_o  <= 1'b0;
            wr_byte_o <= '0;
        end else begin
            wr_stb_o <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                pull_q  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                pull_q <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == BITS_PER_BYTE) begin
                            if (state == ST_ADDR) begin
                                if (rx_sh[7:1] == SLAVE_ADDR) begin
                                    rw_bit <= rx_sh[0];
                                    pull_q <= 1'b1;
                                    state  <= ST_ADDR_ACK;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end else begin
                                wr_stb_o  <= 1'b1;
                                wr_byte_o <= rx_sh;
                                pull_q    <= 1'b1;
                                state     <= ST_DATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rw_bit) begin
                                tx_sh  <= status_i;
                                pull_q <= ~status_i[7];
                                state  <= ST_RDATA;
                            end else begin
                                pull_q <= 1'b0;
                                state  <= ST_WDATA;
                            end
                        end
                    end
                    ST_DATA_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            pull_q  <= 1'b0;
                            state   <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt == BITS_PER_BYTE) begin
                                pull_q <= 1'b0;
                                state  <= ST_RD_ACK;
                            end else begin
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                                pull_q <= ~tx_sh[6];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mst_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (mst_ack) begin
                                bit_cnt <= '0;
                                tx_sh   <= status_i;
                                pull_q  <= ~status_i[7];
                                state   <= ST_RDATA;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull_o = pull_q;

    // R9: the slave only starts pulling SDA in a cycle that saw SCL low.
    a_r9_pull_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_q) |-> !$past(scl_s));

    // R1: the address ACK slot is entered only for the own address.
    a_r1_ack_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> (rx_sh[7:1] == SLAVE_ADDR));

endmodule

// File: rtl/bias_cfg_regs.sv
// Module: bias_cfg_regs
// Holds the two shadow configuration registers and the shared DAC register.
// It selects the live register from the awake pin and gates the panel enable
// with power-good. It also forms the status byte. Assumes awake/pgood are
// synchronized already and that wr_stb_i is a one-cycle pulse.
module bias_cfg_regs
    import smb_bias_pkg::*;
#(
    parameter int DAC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb_i,
    input  logic [7:0]       wr_byte_i,
    input  logic             awake_s,
    input  logic             pg_s,
    output logic             run_o,
    output logic             panel_o,
    output logic [DAC_W-1:0] dac_o,
    output logic [7:0]       status_o
);

    localparam int               SEL_BIT   = 7;
    localparam int               RUN_BIT   = 6;
    localparam int               PANEL_BIT = 5;
    localparam int               N_CFG     = 2;
    localparam logic [DAC_W-1:0] DAC_RST   = DAC_W'(dac_mid(DAC_W));

    bias_cfg_t        cfg_q [N_CFG];
    bias_cfg_t        live;
    logic [DAC_W-1:0] dac_q;
    logic             run_q, panel_q;

    // One register per shadow slot: index 0 standby, index 1 operating.
    for (genvar g = 0; g < N_CFG; g++) begin : g_cfg
        // Load this slot when a byte selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q[g] <= CFG_RESET;
            end else if (wr_stb_i && (int'(wr_byte_i[SEL_BIT]) == g)) begin
                cfg_q[g] <= '{run: wr_byte_i[RUN_BIT], panel: wr_byte_i[PANEL_BIT]};
            end
        end
    end

    // The shared DAC code follows every accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) dac_q <= DAC_RST;
        else if (wr_stb_i) dac_q <= wr_byte_i[DAC_W-1:0];
    end

    assign live = cfg_q[awake_s];

    // Register the supply controls from the live slot and power-good.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= CFG_RESET.run;
            panel_q <= 1'b0;
        end else begin
            run_q   <= live.run;
            panel_q <= live.run & live.panel & pg_s;
        end
    end

    assign run_o    = run_q;
    assign panel_o  = panel_q;
    assign dac_o    = dac_q;
    assign status_o = {awake_s, pg_s, live.run, live.panel, 4'b0000};

    // R5: the DAC code moves only on an accepted write.
    a_r5_dac_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_i |=> $stable(dac_q));

    // R7: low power-good turns the panel off one cycle later.
    a_r7_pgood_gates_panel: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_s |=> !panel_q);

    // R6: the panel is never enabled while the supply is shut down.
    a_r6_panel_off_in_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> !panel_q);

endmodule

// File: rtl/smb_bias_ctrl.sv
// Module: smb_bias_ctrl (top)
// LCD bias supply serial control slave. It synchronizes the bus and pin
// inputs, runs the SMBus byte engine and drives the supply controls from
// the configuration store. Assumes clk is at least about eight times the
// SCL rate and that an external pull-up sits on SDA.
module smb_bias_ctrl
    import smb_bias_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR  = DEF_SLAVE_ADDR,
    parameter int         DAC_W       = 5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    input  logic             awake_i,
    input  logic             pgood_i,
    output logic             run_o,
    output logic             panel_en_o,
    output logic [DAC_W-1:0] dac_o
);

    localparam int         N_SYNC   = 4;
    localparam logic [3:0] SYNC_RST = 4'b0011;  // {pgood, awake, sda, scl}

    logic [N_SYNC-1:0] raw_in, syn_in;
    logic              wr_stb;
    logic [7:0]        wr_byte, status;

    assign raw_in = {pgood_i, awake_i, sda_i, scl_i};

    bit_sync #(.W(N_SYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_in)
    );

    smb_bus_engine #(.SLAVE_ADDR(SLAVE_ADDR)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (syn_in[0]),
        .sda_s      (syn_in[1]),
        .status_i   (status),
        .sda_pull_o (sda_pull_o),
        .wr_stb_o   (wr_stb),
        .wr_byte_o  (wr_byte)
    );

    bias_cfg_regs #(.DAC_W(DAC_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb_i (wr_stb),
        .wr_byte_i(wr_byte),
        .awake_s  (syn_in[2]),
        .pg_s     (syn_in[3]),
        .run_o    (run_o),
        .panel_o  (panel_en_o),
        .dac_o    (dac_o),
        .status_o (status)
    );

endmodule

// File: tb/tb_smb_bias_ctrl.sv
// Bench: bit-level SMBus master with a reference model computed from the
// requirements. It sweeps all data bytes and all foreign addresses and
// exercises status reads.
module tb_smb_bias_ctrl;

    localparam int         Q        = 4;          // clk cycles per quarter SCL bit
    localparam logic [6:0] OWN_ADDR = 7'b0101100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       awake = 1'b0, pgood = 1'b0;
    logic       sda_pull, run, panel;
    logic [4:0] dac;
    logic       sda_line;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Reference model.
    logic       m_run [2];
    logic       m_pan [2];
    logic [4:0] m_dac;

    always #2.5 clk = ~clk;   // 200 MHz

    assign sda_line = sda_m & ~sda_pull;

    smb_bias_ctrl dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .awake_i(awake), .pgood_i(pgood),
        .run_o(run), .panel_en_o(panel), .dac_o(dac)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_reset();
        m_run[0] = 1'b1; m_run[1] = 1'b1;
        m_pan[0] = 1'b0; m_pan[1] = 1'b0;
        m_dac = 5'b10000;
    endtask

    task automatic model_write(input logic [7:0] d);
        m_run[d[7]] = d[6];
        m_pan[d[7]] = d[5];
        m_dac = d[4:0];
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        b = sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        acked = ~a;
    endtask

    task automatic recv_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            v[i] = b;
        end
    endtask

    // Address + write, then always one data byte.
    task automatic write_txn(input logic [6:0] a, input logic [7:0] d,
                             output logic a_ack, output logic d_ack);
        bus_start();
        send_byte({a, 1'b0}, a_ack);
        send_byte(d, d_ack);
        bus_stop();
        wq(8);
    endtask

    function automatic int exp_run();
        return int'(m_run[awake]);
    endfunction

    function automatic int exp_pan();
        return int'(m_run[awake] & m_pan[awake] & pgood);
    endfunction

    task automatic check_outputs(input string tag);
        chk({tag, " R3/R6 run_o"}, int'(run), exp_run());
        chk({tag, " R2/R7 panel_en_o"}, int'(panel), exp_pan());
        chk({tag, " R4 dac_o"}, int'(dac), int'(m_dac));
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic       aa, da, b;
        logic [7:0] st0, st1, exp_st;

        model_reset();
        wq(6);
        rst_n = 1'b1;
        wq(8);

        // R8: reset state.
        chk("R8 reset dac_o", int'(dac), 16);
        chk("R8 reset run_o", int'(run), 1);
        chk("R8 reset panel_en_o", int'(panel), 0);
        chk("R9 reset sda released", int'(sda_pull), 0);

        // R2 R3 R4 R5 R6 R7 R9: sweep every data byte under shifting pins.
        for (int i = 0; i < 256; i++) begin
            awake = i[0] ^ i[3];
            pgood = i[1] | i[2];
            write_txn(OWN_ADDR, 8'(i), aa, da);
            chk("R9 address ACK", int'(aa), 1);
            chk("R9 data ACK", int'(da), 1);
            model_write(8'(i));
            check_outputs("sweep");
            awake = ~awake;
            wq(8);
            chk("R5 dac_o after pin toggle", int'(dac), int'(m_dac));
            chk("R3 run_o after pin toggle", int'(run), exp_run());
        end

        // R1 R5: every foreign address followed by a full data byte.
        awake = 1'b1; pgood = 1'b1;
        write_txn(OWN_ADDR, 8'b1110_0011, aa, da);
        model_write(8'b1110_0011);
        for (int a = 0; a < 128; a++) begin
            if (7'(a) != OWN_ADDR) begin
                write_txn(7'(a), 8'b1000_1100, aa, da);
                chk("R1 foreign address no ACK", int'(aa), 0);
                chk("R1 foreign data no ACK", int'(da), 0);
                chk("R5 dac_o after foreign traffic", int'(dac), int'(m_dac));
                chk("R1 run_o after foreign traffic", int'(run), exp_run());
            end
        end
        chk("R1 panel_en_o after foreign sweep", int'(panel), exp_pan());

        // R6: shut down the operating slot, then bring it back.
        write_txn(OWN_ADDR, 8'b1010_0101, aa, da);
        model_write(8'b1010_0101);
        chk("R6 write accepted", int'(da), 1);
        chk("R6 shutdown run_o", int'(run), 0);
        chk("R6 shutdown panel_en_o", int'(panel), 0);
        chk("R5 dac_o in shutdown", int'(dac), 5);
        write_txn(OWN_ADDR, 8'b1110_0101, aa, da);
        model_write(8'b1110_0101);
        chk("R6 wake-up ACK", int'(da), 1);
        check_outputs("R6 wake-up");

        // R7: power-good low forces the panel off.
        pgood = 1'b0; wq(8);
        chk("R7 panel off with pgood low", int'(panel), 0);
        pgood = 1'b1; wq(8);
        chk("R7 panel back with pgood high", int'(panel), 1);

        // R10: status reads under each pin combination.
        write_txn(OWN_ADDR, 8'b0100_0111, aa, da);
        model_write(8'b0100_0111);
        for (int c = 0; c < 4; c++) begin
            awake = c[0]; pgood = c[1]; wq(8);
            exp_st = {awake, pgood, m_run[awake], m_pan[awake], 4'b0000};
            bus_start();
            send_byte({OWN_ADDR, 1'b1}, aa);
            chk("R10 read address ACK", int'(aa), 1);
            recv_byte(st0);
            chk("R10 status byte", int'(st0), int'(exp_st));
            if (c == 3) begin
                send_bit(1'b0);                // master ACK: another byte
                recv_byte(st1);
                chk("R10 second status byte", int'(st1), int'(exp_st));
            end
            send_bit(1'b1);                    // master NACK
            wq(Q);
            chk("R10 SDA released after NACK", int'(sda_line), 1);
            bus_stop();
            wq(8);
        end

        // R8: reset in the middle of operation.
        write_txn(OWN_ADDR, 8'b0000_0011, aa, da);
        model_write(8'b0000_0011);
        rst_n = 1'b0; wq(3);
        rst_n = 1'b1; model_reset(); wq(8);
        chk("R8 re-reset dac_o", int'(dac), 16);
        awake = 1'b0; wq(8);
        chk("R8 standby slot run after reset", int'(run), 1);
        chk("R8 panel after reset", int'(panel), 0);
        recv_bit(b);
        chk("R9 bus idle after reset", int'(b), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule